// File: doc/BRIEF.md
# SPI Serial Memory Command Front End

This block is the slave-side command engine of a 256-byte, byte-addressed serial memory reached over SPI in clock mode 0 or mode 3. The select, serial clock, serial input and pause inputs are oversampled on the system clock. The engine assembles an opcode and an address and then either streams array bytes out, returns a status byte, moves the write-enable latch, or passes incoming write bytes to a separate page-write controller. The serial output comes with an enable for the pad's tri-state driver.

The array itself sits outside the block. The engine presents a read address and takes the addressed byte back in the same cycle. Write bytes leave as single-cycle strobes carrying their final in-page address. A commit strobe follows when the transaction closes on a byte boundary. The page-write controller reports its internal write cycle on a busy input. While that input is high, only status reads are served.

Top module: `spi_ee_engine`

## Requirements
- R1: Bits are taken on rising SCK edges seen while select is low and pause is high, most significant bit first. The first bit is the first rising edge after select falls, with SCK idling either low (mode 0) or high (mode 3).
- R2: Opcode 03h followed by an address byte puts the array byte at that address on `so`, MSb first. `so` changes only after a falling SCK edge, and `so_oe` is high for every data bit.
- R3: During a read the address advances by one after each 8 output bits and wraps from FFh to 00h, so a read continues until select rises.
- R4: Opcode 05h returns a status byte with bit0 = `wr_busy`, bit1 = write-enable latch, bit2 = `bp[0]`, bit3 = `bp[1]` and bits 7..4 zero. The byte is refreshed and sent again for every further 8 clocks.
- R5: Opcode 06h sets the write-enable latch and 04h clears it. Either takes effect only if select rises after exactly 8 bits of that transaction. Any further bit cancels it.
- R6: Opcode 02h with the latch set takes an address byte and then data bytes. Each complete data byte appears for one cycle on `wr_valid` with `wr_data` and `wr_addr`. The address advances only in its low 4 bits, so it wraps inside its 16-byte page.
- R7: `wr_commit` pulses in the cycle select is seen high after a write phase that holds at least one complete data byte and no partial byte. Opcode 02h without the latch set produces neither `wr_valid` nor `wr_commit`.
- R8: While `wr_busy` is high, opcodes 03h, 02h, 06h and 04h are ignored and drive nothing, and 05h still works. The write-enable latch clears when `wr_busy` falls.
- R9: While `hold_n` is low, SCK and SI are ignored and `so_oe` is low. After `hold_n` rises the transfer resumes at the exact bit where it paused.
- R10: Any other opcode is ignored until select rises. A high select returns the engine to opcode reception from any state, and `so_oe` is high only with select low, pause high and a read or status output phase active.
- R11: After reset `so_oe`, `wr_valid` and `wr_commit` are low and the write-enable latch is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| cs_n | input | 1 | Active-low chip select |
| sck | input | 1 | Serial clock |
| si | input | 1 | Serial data in |
| hold_n | input | 1 | Active-low pause |
| so | output | 1 | Serial data out |
| so_oe | output | 1 | Output enable for the `so` pad driver |
| rd_addr | output | 8 | Array read address |
| rd_data | input | 8 | Array byte at `rd_addr` |
| wr_busy | input | 1 | Internal write cycle in progress |
| bp | input | 2 | Block-protect bits shown in the status byte |
| wr_valid | output | 1 | One-cycle strobe for a received write byte |
| wr_addr | output | 8 | Page-wrapped address of that byte |
| wr_data | output | 8 | The received write byte |
| wr_commit | output | 1 | Write transaction closed on a byte boundary |

## Verification
The hardest situations to reach from the pins are those that depend on exactly where select rises. These are a latch-setting opcode followed by more bits in the same transaction, and a write that ends three bits into a byte. The bench drives individual SCK periods and raises select between bits. Resuming after a pause is equally delicate. The bench pauses mid-byte with SCK high, toggles SCK and SI while paused, and then checks that the streamed bytes still match the array. A busy window is opened right after a commit, so that a read and a status poll land inside it.

// File: rtl/spi_ee_pkg.sv
package spi_ee_pkg;
  localparam int BYTE_W = 8;
  localparam int CNT_W  = $clog2(BYTE_W);

  localparam logic [BYTE_W-1:0] OP_READ  = 8'h03;
  localparam logic [BYTE_W-1:0] OP_WRITE = 8'h02;
  localparam logic [BYTE_W-1:0] OP_WREN  = 8'h06;
  localparam logic [BYTE_W-1:0] OP_WRDI  = 8'h04;
  localparam logic [BYTE_W-1:0] OP_RDSR  = 8'h05;

  typedef enum logic [2:0] {
    PH_OPC, PH_ADDR, PH_RDATA, PH_WDATA, PH_STAT, PH_SETTLE, PH_SKIP
  } phase_e;
endpackage

// File: rtl/spi_ee_edge.sv
module spi_ee_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic sck,
  input  logic hold_n,
  output logic sck_rise,
  output logic sck_fall,
  output logic cs_rise
);
  logic sck_q, cs_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q <= 1'b0;
      cs_q  <= 1'b1;
    end else begin
      sck_q <= sck;
      cs_q  <= cs_n;
    end
  end

  assign sck_rise = sck & ~sck_q & hold_n & ~cs_n;
  assign sck_fall = ~sck & sck_q & hold_n & ~cs_n;
  assign cs_rise  = cs_n & ~cs_q;
endmodule

// File: rtl/spi_ee_cmd.sv
module spi_ee_cmd
  import spi_ee_pkg::*;
#(
  parameter int PAGE_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              sck_rise,
  input  logic              cs_rise,
  input  logic              si,
  input  logic              wr_busy,
  output phase_e            phase,
  output logic [CNT_W-1:0]  bit_cnt,
  output logic [BYTE_W-1:0] ptr,
  output logic              wel,
  output logic              wr_valid,
  output logic [BYTE_W-1:0] wr_addr,
  output logic [BYTE_W-1:0] wr_data,
  output logic              wr_commit
);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

  phase_e            ph_q, ph_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [BYTE_W-2:0] sh_q, sh_d;
  logic [BYTE_W-1:0] ptr_q, ptr_d, wa_q, wa_d, wd_q, wd_d;
  logic              wel_q, wel_d, wen_q, wen_d, rd_q, rd_d;
  logic              have_q, have_d, busy_q, wv_q, wv_d;
  logic [BYTE_W-1:0] byte_in;
  logic              last;

  assign byte_in = {sh_q, si};
  assign last    = (cnt_q == LAST_BIT);

  always_comb begin
    ph_d   = ph_q;
    cnt_d  = cnt_q;
    sh_d   = sh_q;
    ptr_d  = ptr_q;
    wa_d   = wa_q;
    wd_d   = wd_q;
    wel_d  = wel_q;
    wen_d  = wen_q;
    rd_d   = rd_q;
    have_d = have_q;
    wv_d   = 1'b0;
    if (busy_q && !wr_busy) wel_d = 1'b0;
    if (cs_n) begin
      ph_d   = PH_OPC;
      cnt_d  = '0;
      have_d = 1'b0;
      if (cs_rise && ph_q == PH_SETTLE) wel_d = wen_q;
    end else if (sck_rise) begin
      cnt_d = cnt_q + 1'b1;
      sh_d  = byte_in[BYTE_W-2:0];
      unique case (ph_q)
        PH_OPC: if (last) begin
          if (byte_in == OP_RDSR) ph_d = PH_STAT;
          else if (wr_busy) ph_d = PH_SKIP;
          else if (byte_in == OP_READ) begin
            ph_d = PH_ADDR; rd_d = 1'b1;
          end else if (byte_in == OP_WRITE && wel_q) begin
            ph_d = PH_ADDR; rd_d = 1'b0;
          end else if (byte_in == OP_WREN || byte_in == OP_WRDI) begin
            ph_d = PH_SETTLE; wen_d = (byte_in == OP_WREN);
          end else ph_d = PH_SKIP;
        end
        PH_ADDR: if (last) begin
          ptr_d = byte_in;
          ph_d  = rd_q ? PH_RDATA : PH_WDATA;
        end
        PH_RDATA: if (last) ptr_d = ptr_q + 1'b1;
        PH_WDATA: if (last) begin
          wv_d   = 1'b1;
          wd_d   = byte_in;
          wa_d   = ptr_q;
          ptr_d  = {ptr_q[BYTE_W-1:PAGE_W], ptr_q[PAGE_W-1:0] + 1'b1};
          have_d = 1'b1;
        end
        PH_SETTLE: ph_d = PH_SKIP;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= PH_OPC;
      cnt_q  <= '0;
      sh_q   <= '0;
      ptr_q  <= '0;
      wa_q   <= '0;
      wd_q   <= '0;
      wel_q  <= 1'b0;
      wen_q  <= 1'b0;
      rd_q   <= 1'b0;
      have_q <= 1'b0;
      busy_q <= 1'b0;
      wv_q   <= 1'b0;
    end else begin
      ph_q   <= ph_d;
      cnt_q  <= cnt_d;
      sh_q   <= sh_d;
      ptr_q  <= ptr_d;
      wa_q   <= wa_d;
      wd_q   <= wd_d;
      wel_q  <= wel_d;
      wen_q  <= wen_d;
      rd_q   <= rd_d;
      have_q <= have_d;
      busy_q <= wr_busy;
      wv_q   <= wv_d;
    end
  end

  assign phase     = ph_q;
  assign bit_cnt   = cnt_q;
  assign ptr       = ptr_q;
  assign wel       = wel_q;
  assign wr_valid  = wv_q;
  assign wr_addr   = wa_q;
  assign wr_data   = wd_q;
  assign wr_commit = cs_rise && ph_q == PH_WDATA && cnt_q == '0 && have_q;
endmodule

// File: rtl/spi_ee_tx.sv
module spi_ee_tx
  import spi_ee_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sck_fall,
  input  logic              out_phase,
  input  logic              first_bit,
  input  logic [BYTE_W-1:0] src,
  output logic              so
);
  logic [BYTE_W-2:0] tx_q, tx_d;
  logic              so_q, so_d;

  always_comb begin
    tx_d = tx_q;
    so_d = so_q;
    if (sck_fall && out_phase) begin
      if (first_bit) begin
        so_d = src[BYTE_W-1];
        tx_d = src[BYTE_W-2:0];
      end else begin
        so_d = tx_q[BYTE_W-2];
        tx_d = {tx_q[BYTE_W-3:0], 1'b0};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_q <= '0;
      so_q <= 1'b0;
    end else begin
      tx_q <= tx_d;
      so_q <= so_d;
    end
  end

  assign so = so_q;
endmodule

// File: rtl/spi_ee_engine.sv
module spi_ee_engine
  import spi_ee_pkg::*;
#(
  parameter int PAGE_W = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cs_n,
  input  logic       sck,
  input  logic       si,
  input  logic       hold_n,
  output logic       so,
  output logic       so_oe,
  output logic [7:0] rd_addr,
  input  logic [7:0] rd_data,
  input  logic       wr_busy,
  input  logic [1:0] bp,
  output logic       wr_valid,
  output logic [7:0] wr_addr,
  output logic [7:0] wr_data,
  output logic       wr_commit
);
  logic              sck_rise, sck_fall, cs_rise, wel, out_phase;
  phase_e            phase;
  logic [CNT_W-1:0]  bit_cnt;
  logic [BYTE_W-1:0] status, tx_src;

  spi_ee_edge u_edge (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .hold_n(hold_n),
    .sck_rise(sck_rise), .sck_fall(sck_fall), .cs_rise(cs_rise)
  );

  spi_ee_cmd #(.PAGE_W(PAGE_W)) u_cmd (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck_rise(sck_rise),
    .cs_rise(cs_rise), .si(si), .wr_busy(wr_busy), .phase(phase),
    .bit_cnt(bit_cnt), .ptr(rd_addr), .wel(wel), .wr_valid(wr_valid),
    .wr_addr(wr_addr), .wr_data(wr_data), .wr_commit(wr_commit)
  );

  assign status    = {{(BYTE_W-4){1'b0}}, bp[1], bp[0], wel, wr_busy};
  assign out_phase = (phase == PH_RDATA) || (phase == PH_STAT);
  assign tx_src    = (phase == PH_STAT) ? status : rd_data;

  spi_ee_tx u_tx (
    .clk(clk), .rst_n(rst_n), .sck_fall(sck_fall), .out_phase(out_phase),
    .first_bit(bit_cnt == '0), .src(tx_src), .so(so)
  );

  assign so_oe = ~cs_n & hold_n & out_phase;
endmodule

// File: rtl/spi_ee_checker.sv
module spi_ee_checker (
  input logic clk,
  input logic rst_n,
  input logic cs_n,
  input logic sck,
  input logic hold_n,
  input logic so,
  input logic so_oe,
  input logic wr_valid,
  input logic wr_commit,
  input logic wel
);
  AST_OE_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n || !hold_n) |-> !so_oe); // R10
  AST_PAUSE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !hold_n |-> !so_oe); // R9
  AST_SO_FALL_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && $past(!cs_n) && sck && $past(sck)) |-> $stable(so)); // R2
  AST_WEL_AT_DESELECT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wel) |-> cs_n); // R5
  AST_COMMIT_AT_DESELECT: assert property (@(posedge clk) disable iff (!rst_n)
    wr_commit |-> (cs_n && !$past(cs_n))); // R7
  AST_BYTE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |=> !wr_valid); // R6
  AST_BYTE_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> !cs_n); // R6
endmodule

bind spi_ee_engine spi_ee_checker u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .hold_n(hold_n),
  .so(so), .so_oe(so_oe), .wr_valid(wr_valid), .wr_commit(wr_commit),
  .wel(wel)
);

// File: tb/test_spi_ee_engine.sv
`timescale 1ns/1ps
module test_spi_ee_engine;
  localparam int H = 3;

  logic       clk, rst_n, cs_n, sck, si, hold_n, wr_busy;
  logic [1:0] bp;
  logic       so, so_oe, wr_valid, wr_commit;
  logic [7:0] rd_addr, rd_data, wr_addr, wr_data;
  logic [7:0] mem [0:255];
  logic [15:0] exp_wr[$];
  int vectors, fails, commits;
  bit mode3;

  spi_ee_engine i_spi_ee_engine (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .si(si),
    .hold_n(hold_n), .so(so), .so_oe(so_oe), .rd_addr(rd_addr),
    .rd_data(rd_data), .wr_busy(wr_busy), .bp(bp), .wr_valid(wr_valid),
    .wr_addr(wr_addr), .wr_data(wr_data), .wr_commit(wr_commit)
  );

  assign rd_data = mem[rd_addr];

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // every-clock comparison against the reference
  always @(negedge clk) begin
    if (rst_n) begin
      if (cs_n || !hold_n) chk("R10 so_oe gated", so_oe, 1'b0);
      if (wr_valid) begin
        if (exp_wr.size() == 0) chk("R6 unexpected write byte", {wr_addr, wr_data}, 16'hxxxx);
        else chk("R6 write byte", {wr_addr, wr_data}, exp_wr.pop_front());
      end
      if (wr_commit) commits++;
    end
  end

  task automatic do_hold();
    @(negedge clk) hold_n = 1'b0;
    repeat (H) @(negedge clk);
    chk("R9 so_oe low while paused", so_oe, 1'b0);
    for (int k = 0; k < 3; k++) begin
      sck = 1'b0; si = k[0];
      repeat (H) @(negedge clk);
      sck = 1'b1;
      repeat (H) @(negedge clk);
    end
    chk("R9 so_oe still low", so_oe, 1'b0);
    hold_n = 1'b1;
    repeat (H) @(negedge clk);
  endtask

  task automatic bit_xfer(input logic b, output logic sb, output logic soe);
    @(negedge clk) sck = 1'b0; si = b;
    repeat (H) @(negedge clk);
    sb = so; soe = so_oe;
    sck = 1'b1;
    repeat (H) @(negedge clk);
  endtask

  task automatic byte_xfer(input logic [7:0] tx, input int hold_at,
                           output logic [7:0] rx, output int oe_n);
    logic b, e;
    oe_n = 0;
    for (int i = 0; i < 8; i++) begin
      bit_xfer(tx[7-i], b, e);
      rx[7-i] = b;
      oe_n += int'(e);
      if (i == hold_at) do_hold();
    end
  endtask

  task automatic cs_begin();
    @(negedge clk) sck = mode3; si = 1'b0;
    repeat (H) @(negedge clk);
    cs_n = 1'b0;
    repeat (H) @(negedge clk);
  endtask

  task automatic cs_end();
    if (!mode3) begin
      @(negedge clk) sck = 1'b0;
      repeat (H) @(negedge clk);
    end
    @(negedge clk) cs_n = 1'b1;
    repeat (2 * H + 2) @(negedge clk);
  endtask

  task automatic send(input logic [7:0] tx);
    logic [7:0] rx; int n;
    byte_xfer(tx, -1, rx, n);
  endtask

  task automatic read_stream(input string req, input logic [7:0] a,
                             input int nbytes, input int hold_at);
    logic [7:0] rx; int n;
    cs_begin();
    send(8'h03);
    byte_xfer(a, (hold_at >= 8) ? hold_at - 8 : -1, rx, n);
    for (int k = 0; k < nbytes; k++) begin
      byte_xfer(8'h00, (k == 0 && hold_at < 8) ? hold_at : -1, rx, n);
      chk(req, rx, mem[8'(a + k)]);
      chk("R2 so_oe during data", n, 8);
    end
    cs_end();
  endtask

  task automatic status_poll(input string req, input logic [7:0] exp, input int reps);
    logic [7:0] rx; int n;
    cs_begin();
    send(8'h05);
    for (int k = 0; k < reps; k++) begin
      byte_xfer(8'h00, -1, rx, n);
      chk(req, rx, exp);
    end
    cs_end();
  endtask

  task automatic one_op(input logic [7:0] op);
    cs_begin(); send(op); cs_end();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    logic [7:0] rx; int n; logic b, e;
    vectors = 0; fails = 0; commits = 0; mode3 = 1'b0;
    for (int i = 0; i < 256; i++) mem[i] = 8'((i * 37 + 11) ^ (i >> 3));
    rst_n = 1'b0; cs_n = 1'b1; sck = 1'b0; si = 1'b0; hold_n = 1'b1;
    wr_busy = 1'b0; bp = 2'b10;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    chk("R11 so_oe", so_oe, 1'b0);
    chk("R11 wr_valid", wr_valid, 1'b0);
    chk("R11 wr_commit", wr_commit, 1'b0);
    status_poll("R11 latch clear after reset", 8'h08, 1);

    // R1 R2 R3: mode 0 read, then mode 3 read across FFh
    read_stream("R2 mode0 read", 8'h10, 3, 99);
    mode3 = 1'b1;
    read_stream("R3 wrap FFh to 00h", 8'hFE, 4, 99);
    read_stream("R1 mode3 read", 8'h5A, 2, 99);
    mode3 = 1'b0;

    // R5 latch set / clear, R4 status repeats
    one_op(8'h06);
    status_poll("R4 status with latch", 8'h0A, 2);
    one_op(8'h04);
    status_poll("R5 latch cleared", 8'h08, 1);

    // R5 latch opcode followed by further bits: latch stays clear, no write
    cs_begin(); send(8'h06); send(8'h02); send(8'h33); send(8'hC3); cs_end();
    status_poll("R5 extra bits cancel", 8'h08, 1);
    chk("R7 no commit without latch", commits, 0);

    // R7 write without latch
    cs_begin(); send(8'h02); send(8'h40); send(8'h77); cs_end();
    chk("R7 no write without latch", commits, 0);
    chk("R7 no bytes queued", exp_wr.size(), 0);

    // R6 page wrap and commit, mode 3
    mode3 = 1'b1;
    one_op(8'h06);
    exp_wr.push_back({8'h2E, 8'hA1}); exp_wr.push_back({8'h2F, 8'hB2});
    exp_wr.push_back({8'h20, 8'hC3}); exp_wr.push_back({8'h21, 8'hD4});
    cs_begin(); send(8'h02); send(8'h2E);
    send(8'hA1); send(8'hB2); send(8'hC3); send(8'hD4); cs_end();
    chk("R6 all bytes seen", exp_wr.size(), 0);
    chk("R7 commit on boundary", commits, 1);
    mode3 = 1'b0;

    // R8 busy window
    @(negedge clk) wr_busy = 1'b1;
    status_poll("R8 status while busy", 8'h0B, 1);
    cs_begin(); send(8'h03); send(8'h10);
    byte_xfer(8'h00, -1, rx, n);
    chk("R8 read ignored while busy", n, 0);
    cs_end();
    @(negedge clk) wr_busy = 1'b0;
    repeat (3) @(negedge clk);
    status_poll("R8 latch clears after busy", 8'h08, 1);

    // R7 select rises mid-byte: byte delivered, no commit
    one_op(8'h06);
    exp_wr.push_back({8'h83, 8'h5C});
    cs_begin(); send(8'h02); send(8'h83); send(8'h5C);
    for (int i = 0; i < 3; i++) bit_xfer(1'b1, b, e);
    cs_end();
    chk("R7 partial byte no commit", commits, 1);
    chk("R6 full byte before cut", exp_wr.size(), 0);
    one_op(8'h04);

    // R10 unknown opcode
    cs_begin(); send(8'hAB);
    byte_xfer(8'h00, -1, rx, n);
    chk("R10 unknown opcode silent", n, 0);
    byte_xfer(8'hFF, -1, rx, n);
    chk("R10 still silent", n, 0);
    cs_end();
    status_poll("R10 state unaffected", 8'h08, 1);

    // R9 pause mid data byte and mid address byte
    read_stream("R9 resume in data", 8'h40, 3, 3);
    mode3 = 1'b1;
    read_stream("R9 resume in address", 8'h77, 2, 13);
    mode3 = 1'b0;

    repeat (10) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule